// File: doc/BRIEF.md
# Pipeline Hazard and Forwarding Controller

This block is the interlock and bypass decision logic for a five-stage in-order integer pipeline with the stages fetch, decode, execute, memory and write-back. Conditional branches compare their operands in decode and resolve there. The controller is purely combinational. Each cycle it compares the two source register numbers of the instruction in decode with the destination registers of the instructions in execute, memory and write-back. It also compares the two source registers of the instruction in execute with the destinations in memory and write-back.

The controller produces three kinds of output. When a needed value does not exist yet, it holds the program counter and the fetch/decode register and injects a bubble into the decode/execute register. When a branch in decode is taken and not stalled, it flushes the one instruction fetched behind that branch. It also drives the operand multiplexer selects for the ALU in execute and for the branch comparator in decode. A separate flag marks stalls that are caused by a load. The register file is written in the first half of a cycle and read in the second half, so a producer in write-back never forces a stall.

Top module: `pipe_hazard_ctrl`

## Requirements
- R1: A destination register number of 0 never matches a source, so it causes no stall and no forwarding, whatever its write flag is.
- R2: When a non-branch instruction in decode reads the destination of a load in execute, pc_hold, ifid_hold and idex_bubble are 1 and load_use is 1.
- R3: When a branch in decode reads the destination of a non-load writer in execute, the three hold outputs are 1 and load_use is 0.
- R4: When a branch in decode reads the destination of a load in execute or of a load in memory, the three hold outputs are 1 and load_use is 1. A branch behind a load therefore waits two cycles.
- R5: No stall is raised for a non-branch consumer whose producer is a non-load in execute, or is in memory or write-back. No stall is raised for a branch whose producer is a non-load in memory or is in write-back.
- R6: The execute selects ex_fwd_a and ex_fwd_b are 2'b10 when the memory-stage writer matches, 2'b01 when only the write-back writer matches, and 2'b00 otherwise. The memory stage wins when both match.
- R7: The branch selects id_fwd_a and id_fwd_b are 2'b00 when the decode instruction is not a branch. For a branch they are 2'b10 for a matching non-load in memory, otherwise 2'b01 for a matching write-back writer, and otherwise 2'b00.
- R8: ifid_flush is 1 only when a branch in decode is taken and no stall is raised in that cycle. An always-taken compare of x0 with x0 flushes in the same way.
- R9: A stage whose write flag is 0 never matches, even if its register number equals a source.
- R10: pc_hold, ifid_hold and idex_bubble are always equal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| id_rs1 | input | REG_W | First source register of the decode instruction |
| id_rs2 | input | REG_W | Second source register of the decode instruction |
| id_is_branch | input | 1 | Decode instruction compares operands in decode |
| id_br_taken | input | 1 | Comparator result: the branch is taken |
| ex_rs1 | input | REG_W | First source register of the execute instruction |
| ex_rs2 | input | REG_W | Second source register of the execute instruction |
| ex_rd | input | REG_W | Destination register of the execute instruction |
| ex_reg_wr | input | 1 | Execute instruction writes a register |
| ex_is_load | input | 1 | Execute instruction is a load |
| mem_rd | input | REG_W | Destination register of the memory-stage instruction |
| mem_reg_wr | input | 1 | Memory-stage instruction writes a register |
| mem_is_load | input | 1 | Memory-stage instruction is a load |
| wb_rd | input | REG_W | Destination register of the write-back instruction |
| wb_reg_wr | input | 1 | Write-back instruction writes a register |
| pc_hold | output | 1 | Keep the program counter unchanged |
| ifid_hold | output | 1 | Keep the fetch/decode register unchanged |
| idex_bubble | output | 1 | Load a no-op into the decode/execute register |
| ifid_flush | output | 1 | Clear the fetch/decode register (taken branch) |
| load_use | output | 1 | The current stall is caused by a load |
| ex_fwd_a | output | 2 | ALU operand A select: 00 register, 01 write-back, 10 memory stage |
| ex_fwd_b | output | 2 | ALU operand B select, same coding |
| id_fwd_a | output | 2 | Branch comparator operand A select, same coding |
| id_fwd_b | output | 2 | Branch comparator operand B select, same coding |

## Verification
The bench targets the branch-after-load sequence, in which the load is first in execute and then in memory. A design that stalls only once would compare a stale value, and one that forwards an unfinished load from memory would pick select 10 instead of waiting. It sets both forwarding sources to the same register to catch a reversed priority that would feed an older value to the ALU. It also drives register 0 and cleared write flags with matching numbers, where a careless comparator would raise spurious stalls. Finally it applies a taken branch together with a stall; a design that flushed there would drop the branch instruction before it resolves.

// File: rtl/hz_pkg.sv
// Shared definitions for the hazard controller.
// Assumes a two-bit operand select coding used by all bypass multiplexers.
package hz_pkg;
    typedef enum logic [1:0] {
        FWD_REG = 2'b00,   // value from register file / pipeline register
        FWD_WB  = 2'b01,   // value from the write-back stage
        FWD_MEM = 2'b10    // value from the memory stage
    } fwd_sel_e;
endpackage

// File: rtl/hz_src_match.sv
// Compares one source register with one producer destination.
// Assumes register 0 is hard-wired to zero and therefore never a producer.
module hz_src_match #(
    parameter int REG_W = 5
) (
    input  logic [REG_W-1:0] dst,
    input  logic             wr,
    input  logic [REG_W-1:0] src,
    output logic             hit
);
    // Purpose: flag a live read-after-write pairing.
    always_comb begin
        hit = wr && (dst != '0) && (dst == src);
    end
endmodule

// File: rtl/hz_fwd_pick.sv
// Priority picker for one operand multiplexer.
// Assumes the nearer stage holds the younger value; near_ok masks a near
// producer whose data is not ready yet; en forces the register path.
module hz_fwd_pick (
    input  logic       en,
    input  logic       near_hit,
    input  logic       near_ok,
    input  logic       far_hit,
    output logic [1:0] sel
);
    import hz_pkg::*;

    // Purpose: choose the youngest ready producer.
    always_comb begin
        if (!en)
            sel = FWD_REG;
        else if (near_hit && near_ok)
            sel = FWD_MEM;
        else if (far_hit)
            sel = FWD_WB;
        else
            sel = FWD_REG;
    end
endmodule

// File: rtl/hz_stall_logic.sv
// Decides the interlock and the branch flush from per-stage match flags.
// Assumes the branch resolves in decode, so a branch needs its operands
// one stage earlier than an ALU instruction does.
module hz_stall_logic (
    input  logic id_is_branch,
    input  logic id_br_taken,
    input  logic ex_hit,
    input  logic ex_is_load,
    input  logic mem_hit,
    input  logic mem_is_load,
    output logic stall,
    output logic load_use,
    output logic flush
);
    logic ex_load_dep;
    logic br_ex_dep;
    logic br_mem_load_dep;

    // Purpose: classify the dependency cases that need a wait.
    always_comb begin
        ex_load_dep     = ex_hit && ex_is_load;
        br_ex_dep       = id_is_branch && ex_hit;
        br_mem_load_dep = id_is_branch && mem_hit && mem_is_load;
    end

    // Purpose: combine the cases into hold, load flag and flush.
    always_comb begin
        stall    = ex_load_dep || br_ex_dep || br_mem_load_dep;
        load_use = ex_load_dep || br_mem_load_dep;
        flush    = id_is_branch && id_br_taken && !stall;
    end
endmodule

// File: rtl/pipe_hazard_ctrl.sv
// Hazard and bypass controller for a five-stage in-order pipeline with
// branches resolved in decode. Purely combinational.
// Assumes write-back writes the register file before decode reads it in the
// same cycle, and separate instruction and data memories.
module pipe_hazard_ctrl #(
    parameter int REG_W = 5
) (
    input  logic [REG_W-1:0] id_rs1,
    input  logic [REG_W-1:0] id_rs2,
    input  logic             id_is_branch,
    input  logic             id_br_taken,
    input  logic [REG_W-1:0] ex_rs1,
    input  logic [REG_W-1:0] ex_rs2,
    input  logic [REG_W-1:0] ex_rd,
    input  logic             ex_reg_wr,
    input  logic             ex_is_load,
    input  logic [REG_W-1:0] mem_rd,
    input  logic             mem_reg_wr,
    input  logic             mem_is_load,
    input  logic [REG_W-1:0] wb_rd,
    input  logic             wb_reg_wr,
    output logic             pc_hold,
    output logic             ifid_hold,
    output logic             idex_bubble,
    output logic             ifid_flush,
    output logic             load_use,
    output logic [1:0]       ex_fwd_a,
    output logic [1:0]       ex_fwd_b,
    output logic [1:0]       id_fwd_a,
    output logic [1:0]       id_fwd_b
);
    localparam int NSRC = 2;

    logic [REG_W-1:0] id_src [NSRC];
    logic [REG_W-1:0] ex_src [NSRC];
    logic [NSRC-1:0]  id_ex_hit, id_mem_hit, id_wb_hit;
    logic [NSRC-1:0]  ex_mem_hit, ex_wb_hit;
    logic [1:0]       ex_sel [NSRC];
    logic [1:0]       id_sel [NSRC];
    logic             stall;

    // Purpose: gather source operands into indexable arrays.
    always_comb begin
        id_src[0] = id_rs1;
        id_src[1] = id_rs2;
        ex_src[0] = ex_rs1;
        ex_src[1] = ex_rs2;
    end

    for (genvar k = 0; k < NSRC; k++) begin : g_src
        hz_src_match #(.REG_W(REG_W)) u_id_ex (
            .dst(ex_rd),  .wr(ex_reg_wr),  .src(id_src[k]), .hit(id_ex_hit[k]));
        hz_src_match #(.REG_W(REG_W)) u_id_mem (
            .dst(mem_rd), .wr(mem_reg_wr), .src(id_src[k]), .hit(id_mem_hit[k]));
        hz_src_match #(.REG_W(REG_W)) u_id_wb (
            .dst(wb_rd),  .wr(wb_reg_wr),  .src(id_src[k]), .hit(id_wb_hit[k]));
        hz_src_match #(.REG_W(REG_W)) u_ex_mem (
            .dst(mem_rd), .wr(mem_reg_wr), .src(ex_src[k]), .hit(ex_mem_hit[k]));
        hz_src_match #(.REG_W(REG_W)) u_ex_wb (
            .dst(wb_rd),  .wr(wb_reg_wr),  .src(ex_src[k]), .hit(ex_wb_hit[k]));

        hz_fwd_pick u_ex_pick (
            .en(1'b1), .near_hit(ex_mem_hit[k]), .near_ok(1'b1),
            .far_hit(ex_wb_hit[k]), .sel(ex_sel[k]));
        hz_fwd_pick u_id_pick (
            .en(id_is_branch), .near_hit(id_mem_hit[k]), .near_ok(!mem_is_load),
            .far_hit(id_wb_hit[k]), .sel(id_sel[k]));
    end

    hz_stall_logic u_stall (
        .id_is_branch(id_is_branch),
        .id_br_taken (id_br_taken),
        .ex_hit      (|id_ex_hit),
        .ex_is_load  (ex_is_load),
        .mem_hit     (|id_mem_hit),
        .mem_is_load (mem_is_load),
        .stall       (stall),
        .load_use    (load_use),
        .flush       (ifid_flush)
    );

    // Purpose: fan the single stall decision and selects out to the ports.
    always_comb begin
        pc_hold     = stall;
        ifid_hold   = stall;
        idex_bubble = stall;
        ex_fwd_a    = ex_sel[0];
        ex_fwd_b    = ex_sel[1];
        id_fwd_a    = id_sel[0];
        id_fwd_b    = id_sel[1];
    end
endmodule

// File: rtl/pipe_hazard_ctrl_chk.sv
// Checker for the hazard controller: immediate assertions over its ports.
// Assumes it sees the settled outputs of the combinational unit.
module pipe_hazard_ctrl_chk #(
    parameter int REG_W = 5
) (
    input logic [REG_W-1:0] ex_rs1,
    input logic             id_is_branch,
    input logic             pc_hold,
    input logic             ifid_hold,
    input logic             idex_bubble,
    input logic             ifid_flush,
    input logic             load_use,
    input logic [1:0]       ex_fwd_a,
    input logic [1:0]       ex_fwd_b,
    input logic [1:0]       id_fwd_a,
    input logic [1:0]       id_fwd_b
);
    // Purpose: cross-check outputs driven by separate sub-blocks.
    always_comb begin
        a_r10_holds_agree: assert (pc_hold == ifid_hold && ifid_hold == idex_bubble);
        a_r8_no_flush_when_held: assert (!(ifid_flush && idex_bubble));
        a_r8_flush_needs_branch: assert (!ifid_flush || id_is_branch);
        a_r2_load_flag_implies_hold: assert (!load_use || pc_hold);
        a_r7_no_branch_fwd: assert (id_is_branch || (id_fwd_a == 2'b00 && id_fwd_b == 2'b00));
        a_r6_legal_code: assert (ex_fwd_a != 2'b11 && ex_fwd_b != 2'b11);
        a_r1_zero_src_no_fwd: assert (ex_rs1 != '0 || ex_fwd_a == 2'b00);
    end
endmodule

bind pipe_hazard_ctrl pipe_hazard_ctrl_chk #(.REG_W(REG_W)) u_chk (
    .ex_rs1(ex_rs1), .id_is_branch(id_is_branch),
    .pc_hold(pc_hold), .ifid_hold(ifid_hold), .idex_bubble(idex_bubble),
    .ifid_flush(ifid_flush), .load_use(load_use),
    .ex_fwd_a(ex_fwd_a), .ex_fwd_b(ex_fwd_b),
    .id_fwd_a(id_fwd_a), .id_fwd_b(id_fwd_b)
);

// File: tb/pipe_hazard_ctrl_test.sv
module pipe_hazard_ctrl_test;
    localparam int RW = 5;

    logic clk = 1'b0;
    always #2 clk = ~clk;   // 250 MHz

    logic [RW-1:0] id_rs1, id_rs2, ex_rs1, ex_rs2, ex_rd, mem_rd, wb_rd;
    logic id_is_branch, id_br_taken, ex_reg_wr, ex_is_load;
    logic mem_reg_wr, mem_is_load, wb_reg_wr;
    logic pc_hold, ifid_hold, idex_bubble, ifid_flush, load_use;
    logic [1:0] ex_fwd_a, ex_fwd_b, id_fwd_a, id_fwd_b;

    int total = 0;
    int bad = 0;

    pipe_hazard_ctrl #(.REG_W(RW)) uut (
        .id_rs1(id_rs1), .id_rs2(id_rs2), .id_is_branch(id_is_branch),
        .id_br_taken(id_br_taken), .ex_rs1(ex_rs1), .ex_rs2(ex_rs2),
        .ex_rd(ex_rd), .ex_reg_wr(ex_reg_wr), .ex_is_load(ex_is_load),
        .mem_rd(mem_rd), .mem_reg_wr(mem_reg_wr), .mem_is_load(mem_is_load),
        .wb_rd(wb_rd), .wb_reg_wr(wb_reg_wr),
        .pc_hold(pc_hold), .ifid_hold(ifid_hold), .idex_bubble(idex_bubble),
        .ifid_flush(ifid_flush), .load_use(load_use),
        .ex_fwd_a(ex_fwd_a), .ex_fwd_b(ex_fwd_b),
        .id_fwd_a(id_fwd_a), .id_fwd_b(id_fwd_b)
    );

    function automatic bit live(logic [RW-1:0] d, logic w, logic [RW-1:0] s);
        return w && d != 0 && d == s;
    endfunction

    // Expected stall from the requirement text (R2..R5).
    function automatic bit exp_stall();
        bit exd = live(ex_rd, ex_reg_wr, id_rs1) || live(ex_rd, ex_reg_wr, id_rs2);
        bit mmd = live(mem_rd, mem_reg_wr, id_rs1) || live(mem_rd, mem_reg_wr, id_rs2);
        if (id_is_branch) return exd || (mmd && mem_is_load);
        return exd && ex_is_load;
    endfunction

    function automatic bit exp_luse();
        bit exd = live(ex_rd, ex_reg_wr, id_rs1) || live(ex_rd, ex_reg_wr, id_rs2);
        bit mmd = live(mem_rd, mem_reg_wr, id_rs1) || live(mem_rd, mem_reg_wr, id_rs2);
        return (exd && ex_is_load) || (id_is_branch && mmd && mem_is_load);
    endfunction

    function automatic logic [1:0] exp_exsel(logic [RW-1:0] s);
        if (live(mem_rd, mem_reg_wr, s)) return 2'b10;
        if (live(wb_rd, wb_reg_wr, s)) return 2'b01;
        return 2'b00;
    endfunction

    function automatic logic [1:0] exp_idsel(logic [RW-1:0] s);
        if (!id_is_branch) return 2'b00;
        if (live(mem_rd, mem_reg_wr, s) && !mem_is_load) return 2'b10;
        if (live(wb_rd, wb_reg_wr, s)) return 2'b01;
        return 2'b00;
    endfunction

    task automatic chk(string tag, logic [3:0] act, logic [3:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic idle();
        id_rs1 = 0; id_rs2 = 0; id_is_branch = 0; id_br_taken = 0;
        ex_rs1 = 0; ex_rs2 = 0; ex_rd = 0; ex_reg_wr = 0; ex_is_load = 0;
        mem_rd = 0; mem_reg_wr = 0; mem_is_load = 0; wb_rd = 0; wb_reg_wr = 0;
    endtask

    // Full comparison against the bench model after inputs settle.
    task automatic check_all();
        bit st = exp_stall();
        @(negedge clk);
        chk("R10 holds", {1'b0, pc_hold, ifid_hold, idex_bubble}, {1'b0, st, st, st});
        chk("R2/R3/R4/R5 load_use", {3'b0, load_use}, {3'b0, exp_luse()});
        chk("R8 flush", {3'b0, ifid_flush}, {3'b0, id_is_branch && id_br_taken && !st});
        chk("R6 ex sel", {ex_fwd_a, ex_fwd_b}, {exp_exsel(ex_rs1), exp_exsel(ex_rs2)});
        chk("R7 id sel", {id_fwd_a, id_fwd_b}, {exp_idsel(id_rs1), exp_idsel(id_rs2)});
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    initial begin
        #(4 * 150000);
        bad++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int seed = 32'h5eed_1234;
        void'($urandom(seed));
        idle();
        // Quiet state: nothing held, nothing forwarded.
        step(); @(negedge clk);
        chk("R5 quiet hold", {3'b0, pc_hold}, 4'h0);
        chk("R6 quiet sel", {ex_fwd_a, ex_fwd_b}, 4'h0);

        // R1: register 0 as producer with write flag set.
        step(); idle(); id_is_branch = 1; ex_rd = 0; ex_reg_wr = 1; ex_is_load = 1;
        mem_rd = 0; mem_reg_wr = 1; ex_rs1 = 0;
        @(negedge clk);
        chk("R1 x0 no stall", {3'b0, pc_hold}, 4'h0);
        chk("R1 x0 no fwd", {ex_fwd_a, id_fwd_a}, 4'h0);

        // R9: matching number but write flag low.
        step(); idle(); id_rs1 = 7; ex_rd = 7; ex_is_load = 1; ex_rs1 = 9; mem_rd = 9;
        @(negedge clk);
        chk("R9 no wr no stall", {3'b0, pc_hold}, 4'h0);
        chk("R9 no wr no fwd", {2'b0, ex_fwd_a}, 4'h0);

        // R2: load in EX, non-branch consumer.
        step(); idle(); id_rs2 = 4; ex_rd = 4; ex_reg_wr = 1; ex_is_load = 1;
        @(negedge clk);
        chk("R2 load-use stall", {2'b0, pc_hold, load_use}, 4'h3);

        // R5: ALU producer in EX, non-branch consumer: forward later, no stall.
        step(); ex_is_load = 0;
        @(negedge clk);
        chk("R5 alu no stall", {3'b0, idex_bubble}, 4'h0);

        // R3: ALU producer in EX, branch consumer.
        step(); id_is_branch = 1; id_br_taken = 1;
        @(negedge clk);
        chk("R3 branch alu stall", {2'b0, ifid_hold, load_use}, 4'h2);
        chk("R8 stall beats flush", {3'b0, ifid_flush}, 4'h0);

        // R4: branch behind a load, cycle one (EX) then cycle two (MEM).
        step(); idle(); id_is_branch = 1; id_rs1 = 6; ex_rd = 6; ex_reg_wr = 1; ex_is_load = 1;
        @(negedge clk);
        chk("R4 load ex stall", {2'b0, pc_hold, load_use}, 4'h3);
        step(); idle(); id_is_branch = 1; id_rs1 = 6; mem_rd = 6; mem_reg_wr = 1; mem_is_load = 1;
        @(negedge clk);
        chk("R4 load mem stall", {2'b0, pc_hold, load_use}, 4'h3);
        chk("R7 no mem fwd of load", {2'b0, id_fwd_a}, 4'h0);
        // Third cycle: load in WB, branch proceeds with WB select.
        step(); idle(); id_is_branch = 1; id_br_taken = 1; id_rs1 = 6; wb_rd = 6; wb_reg_wr = 1;
        @(negedge clk);
        chk("R5 wb no stall", {3'b0, pc_hold}, 4'h0);
        chk("R7 wb select", {2'b0, id_fwd_a}, 4'h1);
        chk("R8 taken flush", {3'b0, ifid_flush}, 4'h1);

        // R7: non-load in MEM feeds the branch comparator.
        step(); idle(); id_is_branch = 1; id_rs2 = 3; mem_rd = 3; mem_reg_wr = 1;
        @(negedge clk);
        chk("R7 mem select", {id_fwd_a, id_fwd_b}, 4'h2);
        chk("R5 branch mem alu no stall", {3'b0, pc_hold}, 4'h0);

        // R8: always-taken x0/x0 compare flushes one instruction.
        step(); idle(); id_is_branch = 1; id_br_taken = 1; wb_rd = 0; wb_reg_wr = 1;
        @(negedge clk);
        chk("R8 x0 compare flush", {2'b0, ifid_flush, pc_hold}, 4'h2);

        // R6: both stages match the same EX source: memory stage wins.
        step(); idle(); ex_rs1 = 5; ex_rs2 = 8; mem_rd = 5; mem_reg_wr = 1; wb_rd = 5; wb_reg_wr = 1;
        @(negedge clk);
        chk("R6 mem priority", {ex_fwd_a, ex_fwd_b}, 4'h8);
        step(); wb_rd = 8;
        @(negedge clk);
        chk("R6 wb only", {ex_fwd_a, ex_fwd_b}, 4'h9);

        // Random mix with narrow register range to force collisions.
        for (int i = 0; i < 3000; i++) begin
            step();
            id_rs1 = RW'($urandom_range(0, 3)); id_rs2 = RW'($urandom_range(0, 3));
            ex_rs1 = RW'($urandom_range(0, 3)); ex_rs2 = RW'($urandom_range(0, 3));
            ex_rd = RW'($urandom_range(0, 3)); mem_rd = RW'($urandom_range(0, 3));
            wb_rd = RW'($urandom_range(0, 3));
            id_is_branch = 1'($urandom); id_br_taken = 1'($urandom);
            ex_reg_wr = 1'($urandom); ex_is_load = 1'($urandom);
            mem_reg_wr = 1'($urandom); mem_is_load = 1'($urandom);
            wb_reg_wr = 1'($urandom);
            check_all();
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule